// File: doc/BRIEF.md
# Word-Addressed Memory with Mapped Display and Key Input

This block is the data-memory side of a small 16-bit machine. A single word port (address, write data, a load strobe and a read-data output) reaches three targets by address: general-purpose data storage at the bottom of the space, a monochrome bitmap for a 256-row by 512-column display starting at word 16384, and a one-word key input at word 24576. Reads are combinational. The addressed word shows on the output in the same cycle, with no load needed. A write stores the word at the next rising clock edge, and from then on the stored value shows on the output.

The current key code comes in on its own input port, so a test environment can emulate the keyboard. A separate pixel port takes a row and a column and returns that pixel from the bitmap, for display checking. The whole address map is decoded. The number of storage words actually built for data and for display rows is set by parameters. With the defaults, 1024 data words and 64 display rows (2048 bitmap words) are built. Addresses inside a window but past the built storage behave like unmapped addresses.

Top module: `io_mapped_mem`

## Requirements
- R1: A write (load high, reset released) to a data address below `DataWords` stores the word at the next rising edge, and reading that address returns it. Other data words keep their values.
- R2: With load low, the output shows the addressed word in the same cycle the address is applied, and no stored word changes.
- R3: Bitmap words at 16384 up to 16384 + 32*`ScrRows` - 1 are written and read back as in R1.
- R4: Pixel (row r, column c) is bit c mod 16 of the word at 16384 + 32*r + c/16, where bit 0 is the leftmost pixel of its word. A 1 is black and a 0 is white. Rows at or beyond `ScrRows` read as 0.
- R5: Reading address 24576 returns the key code input. This is 0 when no key is down.
- R6: A write to address 24576 has no effect. The key word still reads the key code, and no data or bitmap word changes.
- R7: Writes to unbuilt addresses are dropped, and reads of them return 0. This covers addresses above 24576, data addresses at or beyond `DataWords`, and bitmap addresses past the built rows.
- R8: While reset is asserted (rstN low), load is ignored and no word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rstN | input | 1 | Active-low reset; blocks writes while low |
| addr | input | 16 | Word address |
| wrData | input | 16 | Word to store |
| load | input | 1 | Write strobe |
| keyCode | input | 16 | Current key code, 0 when idle |
| pixRow | input | 8 | Pixel port row |
| pixCol | input | 9 | Pixel port column |
| rdData | output | 16 | Addressed word |
| pixOut | output | 1 | Addressed pixel, 1 = black |

## Verification
The hardest case to reach is an aliasing fault: a write to the key word or to an unbuilt address that wrongly lands in real storage because of a truncated index. That fault is invisible at the address that was written. To expose it, the stimulus first fills the data words that such a write would alias onto (address modulo the data depth), then writes to the key and out-of-range addresses, then reads the pre-filled words back. The pixel mapping is checked by writing words whose set bits sit at the leftmost and rightmost positions, then probing single pixels on both sides of each word boundary.

// File: rtl/io_map_pkg.sv
package io_map_pkg;
  localparam logic [15:0] ScreenBase = 16'd16384;
  localparam logic [15:0] KeyAddr    = 16'd24576;
  localparam int unsigned RowWords   = 32;

  typedef enum logic [1:0] {RegNone, RegData, RegScreen, RegKey} region_e;

  typedef struct packed {
    region_e     region;
    logic        dataWe;
    logic        scrWe;
    logic [13:0] idx;
  } strobes_t;
endpackage

// File: rtl/io_map_ctrl.sv
module io_map_ctrl
  import io_map_pkg::*;
#(
  parameter int unsigned DataWords = 1024,
  parameter int unsigned ScrRows   = 64
) (
  input  logic        rstN,
  input  logic [15:0] addr,
  input  logic        load,
  output strobes_t    strb
);
  localparam int unsigned ScrWords = ScrRows * RowWords;
  localparam logic [15:0] DataEnd  = 16'(DataWords);
  localparam logic [15:0] ScrEnd   = 16'(32'(ScreenBase) + ScrWords);

  logic [15:0] scrOff;
  assign scrOff = addr - ScreenBase;

  always_comb begin
    strb = '0;
    strb.region = RegNone;
    if (addr < DataEnd) begin
      strb.region = RegData;
      strb.idx    = addr[13:0];
      strb.dataWe = load & rstN;
    end else if (addr >= ScreenBase && addr < ScrEnd) begin
      strb.region = RegScreen;
      strb.idx    = scrOff[13:0];
      strb.scrWe  = load & rstN;
    end else if (addr == KeyAddr) begin
      strb.region = RegKey;
    end
  end
endmodule

// File: rtl/io_map_datapath.sv
module io_map_datapath
  import io_map_pkg::*;
#(
  parameter int unsigned DataWords = 1024,
  parameter int unsigned ScrRows   = 64
) (
  input  logic        clk,
  input  strobes_t    strb,
  input  logic [15:0] wrData,
  input  logic [15:0] keyCode,
  input  logic [7:0]  pixRow,
  input  logic [8:0]  pixCol,
  output logic [15:0] rdData,
  output logic        pixOut
);
  localparam int unsigned ScrWords = ScrRows * RowWords;
  localparam int unsigned DataAw   = $clog2(DataWords);
  localparam int unsigned ScrAw    = $clog2(ScrWords);

  logic [15:0] dataMem [DataWords];
  logic [15:0] scrMem  [ScrWords];

  logic [DataAw-1:0] dataIdx;
  logic [ScrAw-1:0]  scrIdx;
  logic [ScrAw-1:0]  pixIdx;
  logic [15:0]       pixWord;

  assign dataIdx = DataAw'(strb.idx);
  assign scrIdx  = ScrAw'(strb.idx);
  assign pixIdx  = ScrAw'({pixRow, pixCol[8:4]});

  always_ff @(posedge clk) begin
    if (strb.dataWe) dataMem[dataIdx] <= wrData;
    if (strb.scrWe)  scrMem[scrIdx]   <= wrData;
  end

  always_comb begin
    unique case (strb.region)
      RegData:   rdData = dataMem[dataIdx];
      RegScreen: rdData = scrMem[scrIdx];
      RegKey:    rdData = keyCode;
      default:   rdData = '0;
    endcase
  end

  always_comb begin
    pixWord = scrMem[pixIdx];
    pixOut  = 1'b0;
    if (32'(pixRow) < ScrRows) pixOut = pixWord[pixCol[3:0]];
  end
endmodule

// File: rtl/io_mapped_mem.sv
module io_mapped_mem
  import io_map_pkg::*;
#(
  parameter int unsigned DataWords = 1024,
  parameter int unsigned ScrRows   = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] addr,
  input  logic [15:0] wrData,
  input  logic        load,
  input  logic [15:0] keyCode,
  input  logic [7:0]  pixRow,
  input  logic [8:0]  pixCol,
  output logic [15:0] rdData,
  output logic        pixOut
);
  strobes_t strb;

  io_map_ctrl #(.DataWords(DataWords), .ScrRows(ScrRows)) uCtrl (
    .rstN(rstN), .addr(addr), .load(load), .strb(strb)
  );

  io_map_datapath #(.DataWords(DataWords), .ScrRows(ScrRows)) uPath (
    .clk(clk), .strb(strb), .wrData(wrData), .keyCode(keyCode),
    .pixRow(pixRow), .pixCol(pixCol), .rdData(rdData), .pixOut(pixOut)
  );
endmodule

// File: rtl/io_mapped_mem_chk.sv
module io_mapped_mem_chk
  import io_map_pkg::*;
#(
  parameter int unsigned DataWords = 1024,
  parameter int unsigned ScrRows   = 64
) (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] addr,
  input logic [15:0] wrData,
  input logic        load,
  input logic [15:0] keyCode,
  input logic [7:0]  pixRow,
  input logic [8:0]  pixCol,
  input logic [15:0] rdData,
  input logic        pixOut
);
  localparam int unsigned ScrEndI = 32'(ScreenBase) + ScrRows * RowWords;

  logic inData, inScr;
  logic [15:0] pixAddr;
  assign inData  = 32'(addr) < DataWords;
  assign inScr   = addr >= ScreenBase && 32'(addr) < ScrEndI;
  assign pixAddr = ScreenBase + 16'({pixRow, pixCol[8:4]});

  a_r5_key_read: assert property (@(posedge clk) disable iff (!rstN)
    (addr == KeyAddr) |-> (rdData == keyCode));

  a_r7_high_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr > KeyAddr) |-> (rdData == 16'd0));

  a_r1_data_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    ($past(load) && $past(rstN) && addr == $past(addr) && inData) |-> (rdData == $past(wrData)));

  a_r3_screen_write_visible: assert property (@(posedge clk) disable iff (!rstN)
    ($past(load) && $past(rstN) && addr == $past(addr) && inScr) |-> (rdData == $past(wrData)));

  a_r4_pixel_matches_word: assert property (@(posedge clk) disable iff (!rstN)
    (addr == pixAddr && 32'(pixRow) < ScrRows) |-> (pixOut == rdData[pixCol[3:0]]));

  a_r2_read_holds: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(load) && $stable(addr) && addr != KeyAddr) |-> $stable(rdData));
endmodule

bind io_mapped_mem io_mapped_mem_chk #(.DataWords(DataWords), .ScrRows(ScrRows)) uChk (
  .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .load(load),
  .keyCode(keyCode), .pixRow(pixRow), .pixCol(pixCol), .rdData(rdData), .pixOut(pixOut)
);

// File: tb/tb_io_mapped_mem.sv
`timescale 1ns/1ps
module tb_io_mapped_mem;
  localparam int DataWords = 1024;
  localparam int ScrRows   = 64;
  localparam int ScrBase   = 16384;
  localparam int KeyA      = 24576;

  logic clk = 0, rstN = 0, load = 0, pixOut;
  logic [15:0] addr = 0, wrData = 0, keyCode = 0, rdData;
  logic [7:0] pixRow = 0;
  logic [8:0] pixCol = 0;
  int total = 0, fails = 0;
  bit done = 0;
  int unsigned model [int];

  always #2.5 clk = ~clk;

  io_mapped_mem #(.DataWords(DataWords), .ScrRows(ScrRows)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .load(load),
    .keyCode(keyCode), .pixRow(pixRow), .pixCol(pixCol), .rdData(rdData), .pixOut(pixOut)
  );

  function automatic bit writable(int a);
    return (a < DataWords) || (a >= ScrBase && a < ScrBase + ScrRows * 32);
  endfunction

  function automatic bit expRead(int a, output int v);
    v = 0;
    if (a == KeyA) begin v = int'(keyCode); return 1; end
    if (writable(a)) begin
      if (model.exists(a)) begin v = int'(model[a]); return 1; end
      return 0;
    end
    return 1;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycle-by-cycle reference model and comparison
  always @(posedge clk) begin
    int v;
    if (rstN && load && writable(int'(addr))) model[int'(addr)] = int'(wrData);
    #2;
    if (!done && expRead(int'(addr), v)) check(int'(rdData) == v, "R2 per-cycle", int'(rdData), v);
  end

  task automatic wr(int a, int d);
    @(negedge clk); addr = 16'(a); wrData = 16'(d); load = 1;
    @(negedge clk); load = 0;
  endtask

  task automatic peek(int a, int exp, string req);
    @(negedge clk); addr = 16'(a); load = 0; #1;
    check(int'(rdData) == exp, req, int'(rdData), exp);
  endtask

  task automatic pix(int r, int c, bit exp, string req);
    @(negedge clk); pixRow = 8'(r); pixCol = 9'(c); #1;
    check(pixOut == exp, req, int'(pixOut), int'(exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; fails++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    addr = 16'(KeyA);
    repeat (3) @(negedge clk);
    #1 check(rdData == 0, "R5 reset idle key", int'(rdData), 0);
    addr = 16'd30000; #1 check(rdData == 0, "R7 reset unmapped", int'(rdData), 0);
    @(negedge clk); rstN = 1;

    // R1 data words
    wr(5, 16'h1234);   peek(5, 16'h1234, "R1 write addr 5");
    wr(0, 16'h0F0F);   wr(1023, 16'hFFFE);
    peek(0, 16'h0F0F, "R1 addr 0"); peek(1023, 16'hFFFE, "R1 top data word");
    peek(5, 16'h1234, "R1 neighbour kept");

    // R2 combinational read, no change without load
    @(negedge clk); addr = 16'd5; #1 check(rdData == 16'h1234, "R2 same-cycle read", int'(rdData), 16'h1234);
    addr = 16'd0; #1 check(rdData == 16'h0F0F, "R2 address switch", int'(rdData), 16'h0F0F);
    wrData = 16'hDEAD; repeat (3) @(negedge clk);
    #1 check(rdData == 16'h0F0F, "R2 no load no change", int'(rdData), 16'h0F0F);

    // R3 bitmap words
    wr(ScrBase, 16'hA5A5); wr(ScrBase + 2047, 16'h5A5A);
    peek(ScrBase, 16'hA5A5, "R3 first bitmap word");
    peek(ScrBase + 2047, 16'h5A5A, "R3 last built bitmap word");

    // R4 pixel mapping
    wr(ScrBase + 32 * 3 + 2, 16'h8001);
    pix(3, 32, 1, "R4 leftmost pixel bit0");
    pix(3, 33, 0, "R4 white pixel");
    pix(3, 47, 1, "R4 rightmost pixel bit15");
    pix(0, 0, 1, "R4 row0 col0");
    pix(0, 1, 0, "R4 row0 col1");
    pix(63, 511, 0, "R4 last built pixel");
    pix(100, 32, 0, "R4 unbuilt row reads white");

    // R5 key input
    keyCode = 16'd65; peek(KeyA, 65, "R5 key code A");
    keyCode = 16'd0;  peek(KeyA, 0, "R5 no key");

    // R6 key write ignored, no aliasing into data word 0
    keyCode = 16'd66; wr(KeyA, 16'h00FF);
    peek(KeyA, 66, "R6 key still reads code");
    peek(0, 16'h0F0F, "R6 data alias kept");
    peek(ScrBase, 16'hA5A5, "R6 bitmap kept");

    // R7 unbuilt addresses
    wr(304, 16'h1111); wr(30000, 16'h7777);
    peek(30000, 0, "R7 high read zero"); peek(304, 16'h1111, "R7 no alias 30000");
    wr(1024, 16'h2222); peek(1024, 0, "R7 past data depth"); peek(0, 16'h0F0F, "R7 no alias 1024");
    wr(ScrBase + 2048, 16'h3333); peek(ScrBase + 2048, 0, "R7 past built rows");
    peek(ScrBase, 16'hA5A5, "R7 bitmap no alias");
    wr(65535, 16'h4444); peek(65535, 0, "R7 top address");
    peek(1023, 16'hFFFE, "R7 data top kept");

    // R8 writes blocked in reset
    @(negedge clk); rstN = 0; addr = 16'd5; wrData = 16'hBEEF; load = 1;
    repeat (2) @(negedge clk); load = 0; rstN = 1;
    peek(5, 16'h1234, "R8 load ignored in reset");

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule